// File: doc/BRIEF.md
# Keyed Shutdown and Wake-up Controller

This block lives in the always-on domain of a chip and owns the system shutdown request. Software turns the system off by writing to a control word. The write takes effect only if it carries the correct password byte together with the shutdown command bit. Once the shutdown output is high, the block watches three wake-up sources:

- an external wake-up pin, which has a selectable level mode and a programmable hold-time filter;
- a real-time-timer event input;
- a real-time-clock event input.

The first qualified event drops the shutdown output and records its cause in a status word. Software reads that word after it powers back up.

The register port is a 32-bit single-cycle bus with three word offsets. Read data is combinational while a read is strobed. A read of the status word clears its flags at the end of that cycle. Everything runs on one slow clock with a synchronous, active-high reset. The event inputs are assumed to be synchronous to that clock. The wake-up pin is asynchronous and goes through a synchronizer.

Top module: `sleep_wake_ctrl`

## Requirements
- R1: Word offsets decode as follows: control is 0x0, mode is 0x4 and status is 0x8. The control word reads as zero. Any other offset reads as zero, and writes to it change nothing.
- R2: A control write with bits [31:24] = 0xA5 and bit 0 = 1 raises the shutdown output on the clock edge that takes the write.
- R3: A control write with any other key byte, or with bit 0 clear, leaves the shutdown output low. So does a keyed value written to any other offset.
- R4: The mode word resets to zero and has four fields:
  - bits [2:0] select the pin mode;
  - bits [7:4] hold the hold count;
  - bit 16 enables timer wake-up;
  - bit 17 enables clock wake-up.
  All other bits read as zero, so writing 0xFFFFFFFF reads back 0x000300F7.
- R5: The pin mode selects the wake-up condition:
  - 1 wakes on a high pin;
  - 2 wakes on a low pin;
  - 3 wakes when the pin differs from its level at shutdown entry;
  - 0 and 4–7 never wake from the pin.
- R6: The pin passes through a two-flop synchronizer, and its condition must hold for H consecutive cycles, where H is the hold count (0–15). After the pin changes just before a clock edge, the shutdown output stays high for 2+H more edges and falls on edge 3+H.
- R7: A pin condition that lasts only H cycles does not wake the system.
- R8: Event input 0 wakes when mode bit 16 is set, and event input 1 wakes when mode bit 17 is set. The shutdown output falls on the clock edge that samples the event. A disabled event has no effect.
- R9: Status bit 0 records a pin wake-up, bit 16 a timer wake-up and bit 17 a clock wake-up. Status is zero after reset. A status read returns the flags and clears them.
- R10: While the shutdown output is low, no source sets a status flag or affects the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow always-on clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while a read is strobed |
| wake_pin | input | 1 | Asynchronous external wake-up pin |
| evt_in | input | NUM_EVT | Timer (bit 0) and clock (bit 1) event inputs |
| shdn_o | output | 1 | Shutdown request, high while the system is down |

## Verification
The bench builds the block with its default parameters: a 4-bit hold count, two event inputs and a two-stage synchronizer. Those values keep the full hold range of 0 to 15 small enough to sweep completely.

For every hold count, the bench runs each active pin mode and both polarities of the change-detect mode, and it checks the exact edge on which the output falls. It also runs every inactive mode code, including 4 to 7. In addition, it checks that pulses exactly one cycle too short are rejected at each hold count, that each event source is enabled and disabled correctly, and that events arriving while the system is up are ignored.

// File: rtl/swc_pkg.sv
package swc_pkg;
   localparam int unsigned REG_W    = 32;
   localparam logic [7:0]  SHDN_KEY = 8'hA5;
   localparam int unsigned KEY_LSB  = 24;
   localparam int unsigned OFS_CTRL = 0;
   localparam int unsigned OFS_MODE = 4;
   localparam int unsigned OFS_STAT = 8;
   localparam int unsigned HOLD_LSB = 4;
   localparam int unsigned EVT_LSB  = 16;
   localparam int unsigned MAX_EVT  = 8;

   typedef enum logic [2:0] {
      PIN_IGNORE = 3'd0,
      PIN_HIGH   = 3'd1,
      PIN_LOW    = 3'd2,
      PIN_TOGGLE = 3'd3
   } pin_mode_e;
endpackage

// File: rtl/swc_sync.sv
module swc_sync #(
   parameter int unsigned STAGES  = 2,
   parameter logic        RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst,
   input  logic d,
   output logic q
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("swc_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk) begin
      if (rst) chain_q <= {STAGES{RST_VAL}};
      else     chain_q <= {chain_q[STAGES-2:0], d};
   end

   assign q = chain_q[STAGES-1];
endmodule

// File: rtl/swc_pin_filter.sv
module swc_pin_filter
   import swc_pkg::*;
#(
   parameter int unsigned HOLD_W = 4
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              pin_s,
   input  logic              down,
   input  logic [2:0]        mode,
   input  logic [HOLD_W-1:0] hold,
   output logic              hit
);
   generate
      if (HOLD_W < 1) begin : g_bad_hold
         $error("swc_pin_filter: HOLD_W must be positive");
      end
   endgenerate

   logic              ref_q;
   logic [HOLD_W-1:0] run_q;
   logic              cond;

   always_comb begin
      case (mode)
         PIN_HIGH:   cond = pin_s;
         PIN_LOW:    cond = ~pin_s;
         PIN_TOGGLE: cond = pin_s ^ ref_q;
         default:    cond = 1'b0;
      endcase
   end

   assign hit = down && cond && (run_q >= hold);

   always_ff @(posedge clk) begin
      if (rst) begin
         ref_q <= 1'b0;
         run_q <= '0;
      end else begin
         if (!down) ref_q <= pin_s;
         if (!down || !cond)  run_q <= '0;
         else if (run_q < hold) run_q <= run_q + 1'b1;
      end
   end
endmodule

// File: rtl/swc_regfile.sv
module swc_regfile
   import swc_pkg::*;
#(
   parameter int unsigned ADDR_W  = 4,
   parameter int unsigned HOLD_W  = 4,
   parameter int unsigned NUM_EVT = 2
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               bus_sel,
   input  logic               bus_wr,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic [REG_W-1:0]   bus_wdata,
   output logic [REG_W-1:0]   bus_rdata,
   input  logic               down,
   input  logic               pin_hit,
   input  logic [NUM_EVT-1:0] evt_in,
   output logic               shdn_req,
   output logic               wake,
   output logic [2:0]         pin_mode,
   output logic [HOLD_W-1:0]  hold,
   output logic [NUM_EVT-1:0] evt_en,
   output logic [NUM_EVT:0]   flags
);
   generate
      if (ADDR_W < 4) begin : g_bad_addr
         $error("swc_regfile: ADDR_W must be at least 4");
      end
      if (HOLD_W > 4) begin : g_bad_hold
         $error("swc_regfile: HOLD_W must not exceed 4");
      end
      if (NUM_EVT < 1 || NUM_EVT > MAX_EVT) begin : g_bad_evt
         $error("swc_regfile: NUM_EVT out of range");
      end
   endgenerate

   localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);
   localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(OFS_MODE);
   localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);

   logic [2:0]         pmode_q;
   logic [HOLD_W-1:0]  hold_q;
   logic [NUM_EVT-1:0] een_q;
   logic               pin_flag_q;
   logic [NUM_EVT-1:0] evt_flag;
   logic [NUM_EVT-1:0] evt_hit;
   logic               wr_mode, rd_stat;
   logic               unused_wdata;

   assign unused_wdata = ^bus_wdata;
   assign wr_mode  = bus_sel && bus_wr && (bus_addr == A_MODE);
   assign rd_stat  = bus_sel && !bus_wr && (bus_addr == A_STAT);
   assign shdn_req = bus_sel && bus_wr && (bus_addr == A_CTRL)
                  && (bus_wdata[KEY_LSB +: 8] == SHDN_KEY) && bus_wdata[0];

   always_ff @(posedge clk) begin
      if (rst) begin
         pmode_q <= '0;
         hold_q  <= '0;
         een_q   <= '0;
      end else if (wr_mode) begin
         pmode_q <= bus_wdata[2:0];
         hold_q  <= bus_wdata[HOLD_LSB +: HOLD_W];
         een_q   <= bus_wdata[EVT_LSB +: NUM_EVT];
      end
   end

   always_ff @(posedge clk) begin
      if (rst)          pin_flag_q <= 1'b0;
      else if (pin_hit) pin_flag_q <= 1'b1;
      else if (rd_stat) pin_flag_q <= 1'b0;
   end

   generate
      for (genvar i = 0; i < NUM_EVT; i++) begin : g_evt
         logic flag_q;
         assign evt_hit[i] = down && een_q[i] && evt_in[i];
         always_ff @(posedge clk) begin
            if (rst)             flag_q <= 1'b0;
            else if (evt_hit[i]) flag_q <= 1'b1;
            else if (rd_stat)    flag_q <= 1'b0;
         end
         assign evt_flag[i] = flag_q;
      end
   endgenerate

   assign wake     = pin_hit || (|evt_hit);
   assign pin_mode = pmode_q;
   assign hold     = hold_q;
   assign evt_en   = een_q;
   assign flags    = {evt_flag, pin_flag_q};

   always_comb begin
      bus_rdata = '0;
      if (bus_sel && !bus_wr) begin
         if (bus_addr == A_MODE) begin
            bus_rdata[2:0]                 = pmode_q;
            bus_rdata[HOLD_LSB +: HOLD_W]  = hold_q;
            bus_rdata[EVT_LSB +: NUM_EVT]  = een_q;
         end else if (bus_addr == A_STAT) begin
            bus_rdata[0]                   = pin_flag_q;
            bus_rdata[EVT_LSB +: NUM_EVT]  = evt_flag;
         end
      end
   end
endmodule

// File: rtl/sleep_wake_ctrl.sv
module sleep_wake_ctrl
   import swc_pkg::*;
#(
   parameter int unsigned ADDR_W      = 4,
   parameter int unsigned HOLD_W      = 4,
   parameter int unsigned NUM_EVT     = 2,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               bus_sel,
   input  logic               bus_wr,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic [31:0]        bus_wdata,
   output logic [31:0]        bus_rdata,
   input  logic               wake_pin,
   input  logic [NUM_EVT-1:0] evt_in,
   output logic               shdn_o
);
   logic               pin_s, pin_hit, shdn_req, wake, shdn_q;
   logic [2:0]         pin_mode;
   logic [HOLD_W-1:0]  hold;
   logic [NUM_EVT-1:0] evt_en;
   logic [NUM_EVT:0]   flags;
   logic               unused_obs;

   assign unused_obs = ^{evt_en, flags};

   swc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync (
      .clk (clk),
      .rst (rst),
      .d   (wake_pin),
      .q   (pin_s)
   );

   swc_pin_filter #(.HOLD_W(HOLD_W)) u_pin (
      .clk   (clk),
      .rst   (rst),
      .pin_s (pin_s),
      .down  (shdn_q),
      .mode  (pin_mode),
      .hold  (hold),
      .hit   (pin_hit)
   );

   swc_regfile #(.ADDR_W(ADDR_W), .HOLD_W(HOLD_W), .NUM_EVT(NUM_EVT)) u_regs (
      .clk       (clk),
      .rst       (rst),
      .bus_sel   (bus_sel),
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .down      (shdn_q),
      .pin_hit   (pin_hit),
      .evt_in    (evt_in),
      .shdn_req  (shdn_req),
      .wake      (wake),
      .pin_mode  (pin_mode),
      .hold      (hold),
      .evt_en    (evt_en),
      .flags     (flags)
   );

   always_ff @(posedge clk) begin
      if (rst)                 shdn_q <= 1'b0;
      else if (shdn_q && wake) shdn_q <= 1'b0;
      else if (shdn_req)       shdn_q <= 1'b1;
   end

   assign shdn_o = shdn_q;
endmodule

// File: rtl/swc_chk.sv
module swc_chk #(
   parameter int unsigned ADDR_W  = 4,
   parameter int unsigned NUM_EVT = 2
) (
   input logic               clk,
   input logic               rst,
   input logic               bus_sel,
   input logic               bus_wr,
   input logic [ADDR_W-1:0]  bus_addr,
   input logic [31:0]        bus_wdata,
   input logic [NUM_EVT-1:0] evt_in,
   input logic [NUM_EVT-1:0] evt_en,
   input logic [NUM_EVT:0]   flags,
   input logic               shdn_o
);
   logic key_wr;
   logic unused_chk;

   assign unused_chk = ^bus_wdata;
   assign key_wr = bus_sel && bus_wr && (bus_addr == '0)
                && (bus_wdata[31:24] == 8'hA5) && bus_wdata[0];

   AST_KEY_ENTERS_SHDN: assert property (@(posedge clk) disable iff (rst)
      (!shdn_o && key_wr) |=> shdn_o);                                   // R2
   AST_SHDN_NEEDS_KEY: assert property (@(posedge clk) disable iff (rst)
      (!shdn_o && !key_wr) |=> !shdn_o);                                 // R3
   AST_EVT_WAKES: assert property (@(posedge clk) disable iff (rst)
      (shdn_o && ((evt_in & evt_en) != '0)) |=> !shdn_o);                // R8
   AST_WAKE_CAUSE: assert property (@(posedge clk) disable iff (rst)
      $fell(shdn_o) |-> (flags != '0));                                  // R9
   AST_IDLE_NO_FLAGS: assert property (@(posedge clk) disable iff (rst)
      !shdn_o |=> ((flags & ~$past(flags)) == '0));                      // R10
endmodule

bind sleep_wake_ctrl swc_chk #(.ADDR_W(ADDR_W), .NUM_EVT(NUM_EVT)) u_chk (
   .clk       (clk),
   .rst       (rst),
   .bus_sel   (bus_sel),
   .bus_wr    (bus_wr),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .evt_in    (evt_in),
   .evt_en    (evt_en),
   .flags     (flags),
   .shdn_o    (shdn_o)
);

// File: tb/sleep_wake_ctrl_bench.sv
`timescale 1ns/1ps
module sleep_wake_ctrl_bench;
   localparam logic [3:0] A_CTRL = 4'h0, A_MODE = 4'h4, A_STAT = 4'h8, A_HOLE = 4'hC;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        bus_sel = 1'b0, bus_wr = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        wake_pin = 1'b0;
   logic [1:0]  evt_in = '0;
   logic        shdn_o;
   int          n_chk = 0, n_bad = 0;
   bit          done = 1'b0;

   always #2.5 clk = ~clk;

   sleep_wake_ctrl u_sleep_wake_ctrl (
      .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .wake_pin(wake_pin), .evt_in(evt_in), .shdn_o(shdn_o)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
      end
   endtask

   task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(posedge clk); @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
   endtask

   task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      #1 d = bus_rdata;
      @(posedge clk); @(negedge clk);
      bus_sel = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   // Wake through an event source, then confirm the status word and its clear.
   task automatic evt_release(input int i);
      logic [31:0] r;
      bus_write(A_MODE, 32'h1 << (16 + i));
      evt_in[i] = 1'b1;
      @(posedge clk); @(negedge clk);
      evt_in[i] = 1'b0;
      check("R8 event wake", {31'd0, shdn_o}, 32'd0);
      bus_read(A_STAT, r);
      check("R9 event flag", r, 32'h1 << (16 + i));
      bus_read(A_STAT, r);
      check("R9 cleared on read", r, 32'd0);
   endtask

   task automatic pin_case(input logic [2:0] md, input int h, input logic lvl_idle,
                           input logic lvl_act, input bit expect_wake);
      logic [31:0] r;
      wake_pin = lvl_idle;
      bus_write(A_MODE, {24'd0, 4'(h), 1'b0, md});
      idle(3);
      bus_write(A_CTRL, 32'hA500_0001);
      check("R2 keyed entry", {31'd0, shdn_o}, 32'd1);
      wake_pin = lvl_act;
      repeat (2 + h) @(posedge clk);
      @(negedge clk);
      check("R6 held before filter expiry", {31'd0, shdn_o}, 32'd1);
      @(posedge clk); @(negedge clk);
      check("R5 pin mode outcome", {31'd0, shdn_o}, {31'd0, !expect_wake});
      if (expect_wake) begin
         bus_read(A_STAT, r);
         check("R9 pin flag", r, 32'h1);
         bus_read(A_STAT, r);
         check("R9 cleared on read", r, 32'd0);
      end else begin
         bus_read(A_STAT, r);
         check("R5 no flag for ignored mode", r, 32'd0);
         evt_release(0);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      logic [31:0] r;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);

      check("R2 reset shutdown low", {31'd0, shdn_o}, 32'd0);
      bus_read(A_MODE, r);  check("R4 mode reset", r, 32'd0);
      bus_read(A_STAT, r);  check("R9 status reset", r, 32'd0);
      bus_read(A_CTRL, r);  check("R1 control reads zero", r, 32'd0);

      bus_write(A_MODE, 32'hFFFF_FFFF);
      bus_read(A_MODE, r);  check("R4 mode mask", r, 32'h0003_00F7);
      bus_write(A_HOLE, 32'h0000_0000);
      bus_read(A_MODE, r);  check("R1 hole write ignored", r, 32'h0003_00F7);
      bus_read(A_HOLE, r);  check("R1 hole reads zero", r, 32'd0);
      bus_write(A_MODE, 32'd0);

      // Wrong keys and misplaced keys.
      bus_write(A_CTRL, 32'hA400_0001); check("R3 bad key", {31'd0, shdn_o}, 32'd0);
      bus_write(A_CTRL, 32'h5A00_0001); check("R3 bad key", {31'd0, shdn_o}, 32'd0);
      bus_write(A_CTRL, 32'hA500_0000); check("R3 bit0 clear", {31'd0, shdn_o}, 32'd0);
      bus_write(A_HOLE, 32'hA500_0001); check("R3 wrong offset", {31'd0, shdn_o}, 32'd0);
      bus_write(A_STAT, 32'hA500_0001); check("R3 wrong offset", {31'd0, shdn_o}, 32'd0);

      // Events while the system is up.
      bus_write(A_MODE, 32'h0003_0000);
      evt_in = 2'b11;
      @(posedge clk); @(negedge clk);
      evt_in = 2'b00;
      check("R10 up events ignored", {31'd0, shdn_o}, 32'd0);
      bus_read(A_STAT, r); check("R10 no flags while up", r, 32'd0);

      // Disabled events while down, then each enabled source.
      bus_write(A_MODE, 32'd0);
      bus_write(A_CTRL, 32'hA500_0001);
      evt_in = 2'b11;
      @(posedge clk); @(negedge clk);
      evt_in = 2'b00;
      check("R8 disabled events", {31'd0, shdn_o}, 32'd1);
      bus_read(A_STAT, r); check("R8 no flag when disabled", r, 32'd0);
      evt_release(0);
      bus_write(A_CTRL, 32'hA500_0001);
      evt_release(1);

      // Full sweep of hold counts across pin modes.
      for (int h = 0; h < 16; h++) begin
         pin_case(3'd1, h, 1'b0, 1'b1, 1'b1);
         pin_case(3'd2, h, 1'b1, 1'b0, 1'b1);
         pin_case(3'd3, h, 1'b0, 1'b1, 1'b1);
         pin_case(3'd3, h, 1'b1, 1'b0, 1'b1);
      end
      for (int m = 0; m < 8; m++) begin
         if (m == 0 || m > 3) begin
            pin_case(3'(m), 0, 1'b0, 1'b1, 1'b0);
            pin_case(3'(m), 0, 1'b1, 1'b0, 1'b0);
         end
      end
      // Toggle mode: returning to the entry level is not a change.
      pin_case(3'd3, 2, 1'b1, 1'b1, 1'b0);

      // R7: pulses one cycle short of the filter are rejected.
      for (int h = 1; h < 16; h++) begin
         wake_pin = 1'b0;
         bus_write(A_MODE, {24'd0, 4'(h), 4'd1});
         idle(3);
         bus_write(A_CTRL, 32'hA500_0001);
         wake_pin = 1'b1;
         repeat (h) @(posedge clk);
         @(negedge clk);
         wake_pin = 1'b0;
         idle(6);
         check("R7 short pulse rejected", {31'd0, shdn_o}, 32'd1);
         bus_read(A_STAT, r); check("R7 no pin flag", r, 32'd0);
         evt_release(1);
      end

      finish_run();
   end
endmodule